// File: doc/BRIEF.md
# DMA Debug Comparator Halt Unit

This unit sits beside a DMA engine and watches four of its live quantities: the address being written, the address being read, the number of the task now running, and the current descriptor pointer. Each quantity arrives with its own valid strobe. The unit has a set of comparators. Each comparator has a control word, a match value and an ignore mask. The control word enables the comparator and picks the quantity it watches.

When an enabled comparator sees its chosen quantity valid and equal to its value, the unit raises a halt line to the engine. Bits set in the mask are left out of the comparison, so a comparator can cover an aligned address window. The unit records which source fired and which comparators hit. The halt and the record stay in place until software writes a release bit.

Software reaches the comparators and the status word through a simple register port. Writes are registered and reads are combinational.

Top module: `dma_dbg_halt`

## Requirements
- R1: After reset, `dma_halt` is low, the status word (address 0) reads zero, and every comparator register reads zero, so every comparator starts disabled.
- R2: Comparator i has its registers at addresses 4*(i+1) (control), 4*(i+1)+1 (value) and 4*(i+1)+2 (mask). Control bit 0 is the enable and control bits 2:1 are the source. A written value reads back unchanged from the next cycle on.
- R3: The source codes are 0 for write address, 1 for read address, 2 for task number and 3 for descriptor pointer. The task number is zero-extended before it is compared. Only the selected source can cause a match.
- R4: A comparator compares only in a cycle in which the valid strobe of its selected source is high. A matching value with a low strobe has no effect.
- R5: A mask bit set to 1 leaves the matching bit position out of the comparison. All other positions must be equal.
- R6: A match in an enabled comparator during cycle N makes `dma_halt` high after clock edge N.
- R7: A comparator whose enable bit is 0 never causes a halt, whatever its inputs.
- R8: `dma_halt` stays high until a write to address 0 with data bit 0 set, which clears it at the next edge. A write to address 0 with bit 0 clear has no effect.
- R9: The status word holds the halted flag in bit 0 and, in bits 2:1, the source of the lowest-numbered comparator that matched in the halting cycle. Bit 3+i is set for each comparator i that matched in that cycle. `halt_src` shows bits 2:1 of the status word. A release clears the whole status word.
- R10: While the unit is halted, and in the cycle of the release write, further matches are ignored and the status word stays frozen. After the release, a later match halts the engine again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | ADDR_W | Register write address |
| cfg_wdata | input | DW | Register write data |
| cfg_raddr | input | ADDR_W | Register read address |
| cfg_rdata | output | DW | Register read data (combinational) |
| mon_waddr | input | DW | Engine write address |
| mon_waddr_vld | input | 1 | Write address valid |
| mon_raddr | input | DW | Engine read address |
| mon_raddr_vld | input | 1 | Read address valid |
| mon_task | input | TASK_W | Current task number |
| mon_task_vld | input | 1 | Task number valid |
| mon_dptr | input | DW | Current descriptor pointer |
| mon_dptr_vld | input | 1 | Descriptor pointer valid |
| dma_halt | output | 1 | Halt request to the engine |
| halt_src | output | 2 | Source code of the recorded match |

## Verification
Assertions check on every cycle that the halt holds until a release, that a release always drops it, that the status stays frozen while halted, that a unit with no comparator enabled never starts a halt, that a rising halt always has a hit recorded, and that no comparator matches without the valid strobe of its selected source. The bench scenarios cover what these cycle rules cannot show. They confirm that each source code selects the right quantity, that masks widen the match window, that the lowest comparator wins the source field when two match together, and that the register map reads back what was written.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
    typedef enum logic [1:0] {
        SRC_WADDR = 2'd0,
        SRC_RADDR = 2'd1,
        SRC_TASK  = 2'd2,
        SRC_DPTR  = 2'd3
    } dbg_src_e;

    // register offsets inside one comparator's window of four
    localparam int OFS_CTRL = 0;
    localparam int OFS_VAL  = 1;
    localparam int OFS_MASK = 2;
    localparam int WIN_SIZE = 4;
endpackage

// File: rtl/dbg_src_sel.sv
module dbg_src_sel
    import dbg_halt_pkg::*;
#(
    parameter int DW     = 32,
    parameter int TASK_W = 4
) (
    input  dbg_src_e          sel,
    input  logic [DW-1:0]     mon_waddr,
    input  logic              mon_waddr_vld,
    input  logic [DW-1:0]     mon_raddr,
    input  logic              mon_raddr_vld,
    input  logic [TASK_W-1:0] mon_task,
    input  logic              mon_task_vld,
    input  logic [DW-1:0]     mon_dptr,
    input  logic              mon_dptr_vld,
    output logic [DW-1:0]     src_val,
    output logic              src_vld
);
    always_comb begin
        unique case (sel)
            SRC_WADDR: begin src_val = mon_waddr; src_vld = mon_waddr_vld; end
            SRC_RADDR: begin src_val = mon_raddr; src_vld = mon_raddr_vld; end
            SRC_TASK:  begin src_val = DW'(mon_task); src_vld = mon_task_vld; end
            default:   begin src_val = mon_dptr;  src_vld = mon_dptr_vld;  end
        endcase
    end
endmodule

// File: rtl/dbg_cmp_lane.sv
module dbg_cmp_lane
    import dbg_halt_pkg::*;
#(
    parameter int DW     = 32,
    parameter int TASK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_val,
    input  logic              wr_mask,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     mon_waddr,
    input  logic              mon_waddr_vld,
    input  logic [DW-1:0]     mon_raddr,
    input  logic              mon_raddr_vld,
    input  logic [TASK_W-1:0] mon_task,
    input  logic              mon_task_vld,
    input  logic [DW-1:0]     mon_dptr,
    input  logic              mon_dptr_vld,
    output logic              en,
    output dbg_src_e          sel,
    output logic [DW-1:0]     cval,
    output logic [DW-1:0]     cmask,
    output logic              match
);
    typedef struct packed {
        logic          en;
        dbg_src_e      sel;
        logic [DW-1:0] val;
        logic [DW-1:0] mask;
    } lane_t;

    lane_t ln_d, ln_q;
    logic [DW-1:0] src_val;
    logic          src_vld;

    always_comb begin
        ln_d = ln_q;
        if (wr_ctrl) begin
            ln_d.en  = wdata[0];
            ln_d.sel = dbg_src_e'(wdata[2:1]);
        end
        if (wr_val)  ln_d.val  = wdata;
        if (wr_mask) ln_d.mask = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    dbg_src_sel #(.DW(DW), .TASK_W(TASK_W)) u_sel (
        .sel           (ln_q.sel),
        .mon_waddr     (mon_waddr),
        .mon_waddr_vld (mon_waddr_vld),
        .mon_raddr     (mon_raddr),
        .mon_raddr_vld (mon_raddr_vld),
        .mon_task      (mon_task),
        .mon_task_vld  (mon_task_vld),
        .mon_dptr      (mon_dptr),
        .mon_dptr_vld  (mon_dptr_vld),
        .src_val       (src_val),
        .src_vld       (src_vld)
    );

    assign match = ln_q.en && src_vld && (((src_val ^ ln_q.val) & ~ln_q.mask) == '0);
    assign en    = ln_q.en;
    assign sel   = ln_q.sel;
    assign cval  = ln_q.val;
    assign cmask = ln_q.mask;

    // R4: a match needs the strobe of the selected source, checked at the ports
    assert_match_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ((ln_q.sel == SRC_WADDR) ? mon_waddr_vld :
                   (ln_q.sel == SRC_RADDR) ? mon_raddr_vld :
                   (ln_q.sel == SRC_TASK)  ? mon_task_vld  : mon_dptr_vld));
endmodule

// File: rtl/dma_dbg_halt.sv
module dma_dbg_halt
    import dbg_halt_pkg::*;
#(
    parameter int DW       = 32,
    parameter int TASK_W   = 4,
    parameter int NUM_CMP  = 2,
    localparam int ADDR_W  = $clog2(WIN_SIZE * (NUM_CMP + 1))
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_waddr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic [ADDR_W-1:0] cfg_raddr,
    output logic [DW-1:0]     cfg_rdata,
    input  logic [DW-1:0]     mon_waddr,
    input  logic              mon_waddr_vld,
    input  logic [DW-1:0]     mon_raddr,
    input  logic              mon_raddr_vld,
    input  logic [TASK_W-1:0] mon_task,
    input  logic              mon_task_vld,
    input  logic [DW-1:0]     mon_dptr,
    input  logic              mon_dptr_vld,
    output logic              dma_halt,
    output logic [1:0]        halt_src
);
    localparam int STAT_W = 3 + NUM_CMP;

    typedef struct packed {
        logic               halt;
        dbg_src_e           src;
        logic [NUM_CMP-1:0] hit;
    } stat_t;

    stat_t st_d, st_q;

    logic [NUM_CMP-1:0] match_vec;
    logic [NUM_CMP-1:0] en_vec;
    dbg_src_e           lane_sel  [NUM_CMP];
    logic [DW-1:0]      lane_val  [NUM_CMP];
    logic [DW-1:0]      lane_mask [NUM_CMP];
    logic               release_wr;
    dbg_src_e           first_src;

    assign release_wr = cfg_we && (cfg_waddr == '0) && cfg_wdata[0];

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
        localparam int BASE = WIN_SIZE * (i + 1);
        dbg_cmp_lane #(.DW(DW), .TASK_W(TASK_W)) u_lane (
            .clk           (clk),
            .rst_n         (rst_n),
            .wr_ctrl       (cfg_we && (cfg_waddr == ADDR_W'(BASE + OFS_CTRL))),
            .wr_val        (cfg_we && (cfg_waddr == ADDR_W'(BASE + OFS_VAL))),
            .wr_mask       (cfg_we && (cfg_waddr == ADDR_W'(BASE + OFS_MASK))),
            .wdata         (cfg_wdata),
            .mon_waddr     (mon_waddr),
            .mon_waddr_vld (mon_waddr_vld),
            .mon_raddr     (mon_raddr),
            .mon_raddr_vld (mon_raddr_vld),
            .mon_task      (mon_task),
            .mon_task_vld  (mon_task_vld),
            .mon_dptr      (mon_dptr),
            .mon_dptr_vld  (mon_dptr_vld),
            .en            (en_vec[i]),
            .sel           (lane_sel[i]),
            .cval          (lane_val[i]),
            .cmask         (lane_mask[i]),
            .match         (match_vec[i])
        );
    end

    // lowest-numbered matching comparator names the source
    always_comb begin
        first_src = SRC_WADDR;
        for (int i = NUM_CMP - 1; i >= 0; i--) begin
            if (match_vec[i]) first_src = lane_sel[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.halt) begin
            if (release_wr) st_d = '0;
        end else if (|match_vec) begin
            st_d.halt = 1'b1;
            st_d.src  = first_src;
            st_d.hit  = match_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_raddr == '0) begin
            cfg_rdata[STAT_W-1:0] = {st_q.hit, st_q.src, st_q.halt};
        end
        for (int i = 0; i < NUM_CMP; i++) begin
            if (cfg_raddr == ADDR_W'(WIN_SIZE * (i + 1) + OFS_CTRL))
                cfg_rdata = DW'({lane_sel[i], en_vec[i]});
            if (cfg_raddr == ADDR_W'(WIN_SIZE * (i + 1) + OFS_VAL))
                cfg_rdata = lane_val[i];
            if (cfg_raddr == ADDR_W'(WIN_SIZE * (i + 1) + OFS_MASK))
                cfg_rdata = lane_mask[i];
        end
    end

    assign dma_halt = st_q.halt;
    assign halt_src = st_q.src;

    assert_halt_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && !release_wr) |=> dma_halt);

    assert_release_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && release_wr) |=> !dma_halt);

    assert_status_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_halt && !release_wr) |=> ($stable(st_q.hit) && $stable(halt_src)));

    assert_no_halt_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_halt && (en_vec == '0)) |=> !dma_halt);

    assert_hit_recorded_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_halt) |-> (st_q.hit != '0));
endmodule

// File: tb/tb_dma_dbg_halt.sv
module tb_dma_dbg_halt;
    localparam int DW = 32;
    localparam int TW = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_waddr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_raddr = '0;
    logic [DW-1:0] cfg_rdata;
    logic [DW-1:0] mon_waddr = '0, mon_raddr = '0, mon_dptr = '0;
    logic [TW-1:0] mon_task = '0;
    logic          mon_waddr_vld = 1'b0, mon_raddr_vld = 1'b0;
    logic          mon_task_vld = 1'b0, mon_dptr_vld = 1'b0;
    logic          dma_halt;
    logic [1:0]    halt_src;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    dma_dbg_halt #(.DW(DW), .TASK_W(TW), .NUM_CMP(2)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .mon_waddr(mon_waddr), .mon_waddr_vld(mon_waddr_vld),
        .mon_raddr(mon_raddr), .mon_raddr_vld(mon_raddr_vld),
        .mon_task(mon_task), .mon_task_vld(mon_task_vld),
        .mon_dptr(mon_dptr), .mon_dptr_vld(mon_dptr_vld),
        .dma_halt(dma_halt), .halt_src(halt_src)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [31:0] val;
        logic [31:0] mask;
        logic [31:0] wa;
        logic [31:0] ra;
        logic [3:0]  tn;
        logic [31:0] dp;
        logic [3:0]  vld;   // {dptr, task, raddr, waddr}
        logic        exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 32'h1000, 32'h0, 32'h1000, 32'h0,    4'd0, 32'h0,    4'b0001, 1'b1},
        '{2'd0, 32'h1000, 32'h0, 32'h1004, 32'h0,    4'd0, 32'h0,    4'b0001, 1'b0},
        '{2'd0, 32'h1000, 32'hF, 32'h100C, 32'h0,    4'd0, 32'h0,    4'b0001, 1'b1},
        '{2'd1, 32'h2000, 32'h0, 32'h0,    32'h2000, 4'd0, 32'h0,    4'b0010, 1'b1},
        '{2'd1, 32'h2000, 32'h0, 32'h0,    32'h2000, 4'd0, 32'h0,    4'b0001, 1'b0},
        '{2'd2, 32'h5,    32'h0, 32'h0,    32'h0,    4'd5, 32'h0,    4'b0100, 1'b1},
        '{2'd2, 32'h5,    32'h0, 32'h5,    32'h0,    4'd6, 32'h0,    4'b0101, 1'b0},
        '{2'd3, 32'hABC0, 32'h0, 32'h0,    32'h0,    4'd0, 32'hABC0, 4'b1000, 1'b1}
    };

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
        cfg_raddr = a;
        return cfg_rdata;
    endfunction

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        cfg_raddr = a;
        #0.1;
        check(req, cfg_rdata, exp);
    endtask

    // one cycle of monitored traffic, then back to idle; returns at the negedge after
    task automatic pulse(input logic [DW-1:0] wa, ra, dp, input logic [TW-1:0] tn, input logic [3:0] v);
        @(negedge clk);
        mon_waddr = wa; mon_raddr = ra; mon_dptr = dp; mon_task = tn;
        {mon_dptr_vld, mon_task_vld, mon_raddr_vld, mon_waddr_vld} = v;
        @(negedge clk);
        {mon_dptr_vld, mon_task_vld, mon_raddr_vld, mon_waddr_vld} = 4'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 halt", DW'(dma_halt), 0);
        read_chk("R1 status", 4'd0, 0);
        read_chk("R1 ctrl0", 4'd4, 0);
        read_chk("R1 mask1", 4'd10, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback
        wr(4'd10, 32'h0000_00F0);
        read_chk("R2 mask1 readback", 4'd10, 32'h0000_00F0);
        wr(4'd8, 32'h5);
        read_chk("R2 ctrl1 readback", 4'd8, 32'h5);
        wr(4'd8, 32'h0);
        wr(4'd10, 32'h0);

        // vector table: R3 R4 R5 R6 R9 via comparator 0
        for (int k = 0; k < NV; k++) begin
            wr(4'd4, DW'({VECS[k].sel, 1'b1}));
            wr(4'd5, VECS[k].val);
            wr(4'd6, VECS[k].mask);
            pulse(VECS[k].wa, VECS[k].ra, VECS[k].dp, VECS[k].tn, VECS[k].vld);
            check($sformatf("R3/R4/R5/R6 vec%0d halt", k), DW'(dma_halt), DW'(VECS[k].exp));
            if (VECS[k].exp) begin
                check($sformatf("R9 vec%0d halt_src", k), DW'(halt_src), DW'(VECS[k].sel));
                read_chk($sformatf("R9 vec%0d status", k), 4'd0,
                         DW'({2'b01, VECS[k].sel, 1'b1}));
                wr(4'd0, 32'h1);
                check($sformatf("R8 vec%0d release", k), DW'(dma_halt), 0);
            end
        end

        // R7: disabled comparator ignores a matching input
        wr(4'd4, 32'h0);
        wr(4'd5, 32'h7777);
        pulse(32'h7777, 0, 0, 0, 4'b0001);
        check("R7 disabled no halt", DW'(dma_halt), 0);

        // R9 priority: both comparators match together, comparator 0 on read addr, 1 on write addr
        wr(4'd4, 32'h3);           // src 1, enabled
        wr(4'd5, 32'h40);
        wr(4'd6, 32'h0);
        wr(4'd8, 32'h1);           // src 0, enabled
        wr(4'd9, 32'h80);
        pulse(32'h80, 32'h40, 0, 0, 4'b0011);
        check("R9 both halt", DW'(dma_halt), 1);
        read_chk("R9 both status", 4'd0, 32'b11_01_1);

        // R8: write with bit0 clear keeps the halt
        wr(4'd0, 32'h2);
        check("R8 no release on bit0=0", DW'(dma_halt), 1);

        // R10: extra match while halted leaves status frozen (comparator 1 only)
        pulse(32'h80, 0, 0, 0, 4'b0001);
        read_chk("R10 frozen status", 4'd0, 32'b11_01_1);

        // R10: match in the release cycle is dropped
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = 4'd0; cfg_wdata = 32'h1;
        mon_waddr = 32'h80; mon_waddr_vld = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; mon_waddr_vld = 1'b0;
        check("R10 release-cycle match dropped", DW'(dma_halt), 0);
        read_chk("R9 status cleared", 4'd0, 0);

        // R10: later match halts again, comparator 1 alone
        pulse(32'h80, 0, 0, 0, 4'b0001);
        check("R10 re-halt", DW'(dma_halt), 1);
        read_chk("R10 re-halt status", 4'd0, 32'b10_00_1);
        check("R9 halt_src re-halt", DW'(halt_src), 0);
        wr(4'd0, 32'h1);
        check("R8 final release", DW'(dma_halt), 0);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule